// File: doc/BRIEF.md
# Stored Wiper Register Bank Controller

This block holds the nonvolatile settings of a four-channel digitally controlled resistor: each channel owns four 6-bit stored registers. A command decoder upstream turns bus transactions into single-cycle requests. The block serves reads of a stored register, writes of a stored register, copies of one stored register into a channel wiper, copies of a channel wiper into a stored register, and two all-channel forms of these copies: a recall and a save. The wiper registers live outside the block. The block presents their present values on one input bus and drives load strobes and load data on another.

Any request that changes stored data is only accepted and held as pending. The change takes effect on the end-of-command strobe, which the decoder raises when it detects the bus stop condition. That strobe also starts an emulated high-voltage write cycle. During this cycle a busy flag stays high for a parameterised number of clock cycles. While a write is pending or busy, further store-modifying requests are dropped without notice.

A low write-protect input turns away store-modifying requests and pulses a reject flag. Recalls into the wipers are volatile and never raise busy. After reset, register 0 of every channel is loaded into its wiper once.

Top module: `nvreg_bank_ctrl`

## Requirements
- R1: While reset is asserted, busy, reject, rd_valid and wip_ld are all 0. The cycle after internal reset release, wip_ld is all ones, and each lane of wip_ld_data holds register 0 of its channel, which resets to RST_VAL. On the following cycle wip_ld is 0.
- R2: A read request (req_op 3'd1) gives rd_valid=1 on the next cycle, with rd_data equal to stored register req_reg of channel req_ch. Reads are served while busy.
- R3: A stored write request (req_op 3'd0) is held pending. A read before cmd_stop returns the old value. After cmd_stop the register holds req_wdata.
- R4: busy rises the cycle after the cmd_stop edge that commits a pending change and stays high for exactly BUSY_CYCLES cycles. A cmd_stop with nothing pending leaves busy low.
- R5: A register-to-wiper copy (req_op 3'd2) gives, on the next cycle, wip_ld one-hot at bit req_ch, with that lane of wip_ld_data holding register req_reg of that channel. busy does not rise.
- R6: A global recall (req_op 3'd4) gives, on the next cycle, wip_ld all ones, with lane c of wip_ld_data holding register req_reg of channel c.
- R7: A wiper-to-register copy (req_op 3'd3) stores lane req_ch of wip_cur, as sampled at the request, into register req_reg of channel req_ch when cmd_stop arrives.
- R8: A global save (req_op 3'd5) stores every lane c of wip_cur, as sampled at the request, into register req_reg of channel c when cmd_stop arrives.
- R9: With wp_n low, a store-modifying request (op 0, 3 or 5) raises reject for the next cycle only. No register changes, and the following cmd_stop leaves busy low.
- R10: While a change is pending or busy is high, store-modifying requests are ignored: no reject, no register change, and the first pending value wins.
- R11: Outside the reset recall and the recall requests of R5 and R6, wip_ld stays 0. When nonzero it is either one-hot or all ones. wip_cur lanes are channel-ordered, with lane c at bits [c*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Single-cycle request strobe from the command decoder |
| req_op | input | 3 | Request code (0 write, 1 read, 2 reg-to-wiper, 3 wiper-to-reg, 4 global recall, 5 global save) |
| req_reg | input | 2 | Stored register select |
| req_ch | input | 2 | Channel select |
| req_wdata | input | 6 | Data for a stored write |
| wp_n | input | 1 | Write protect, active low |
| cmd_stop | input | 1 | End-of-command strobe; commits a pending change |
| wip_cur | input | 24 | Present wiper values, lane c at [c*6 +: 6] |
| busy | output | 1 | Emulated write cycle in progress |
| reject | output | 1 | One-cycle pulse for a write-protected request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 6 | Read data |
| wip_ld | output | 4 | Per-channel wiper load strobe |
| wip_ld_data | output | 24 | Wiper load data, lane c at [c*6 +: 6] |

## Verification
The bench builds the block with BUSY_CYCLES set to 6 and RST_VAL set to 33. The default BUSY_CYCLES represents milliseconds of clock time. With the short value, the exact busy length, a request dropped during the busy window, and a stop with nothing pending can all be observed within a few dozen cycles. The non-trivial reset value separates the power-up recall from an all-zero wiper load. It also shows that a write-protected or ignored request left the stored data unchanged.

// File: rtl/nvreg_pkg.sv
package nvreg_pkg;

  typedef enum logic [2:0] {
    OP_WR_REG     = 3'd0,
    OP_RD_REG     = 3'd1,
    OP_REG2WIP    = 3'd2,
    OP_WIP2REG    = 3'd3,
    OP_GLB_RECALL = 3'd4,
    OP_GLB_SAVE   = 3'd5
  } nv_op_e;

  function automatic logic op_modifies(input logic [2:0] op);
    return (op == OP_WR_REG) || (op == OP_WIP2REG) || (op == OP_GLB_SAVE);
  endfunction

endpackage

// File: rtl/nvreg_rst_sync.sv
module nvreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/nvreg_wcycle.sv
module nvreg_wcycle #(
  parameter int unsigned BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CNTW = $clog2(BUSY_CYCLES + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CNTW'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/nvreg_store.sv
module nvreg_store #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_REG = 4,
  parameter int unsigned DW      = 6,
  parameter int unsigned RST_VAL = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CH-1:0]                wr_en,
  input  logic [$clog2(NUM_REG)-1:0]       wr_sel,
  input  logic [NUM_CH*DW-1:0]             wr_data,
  output logic [NUM_CH*NUM_REG*DW-1:0]     store_flat
);

  localparam int unsigned RW = $clog2(NUM_REG);
  localparam logic [DW-1:0] RST_CODE = DW'(RST_VAL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      logic [DW-1:0] cell_q;
      logic          cell_en;

      assign cell_en = wr_en[c] && (wr_sel == RW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= RST_CODE;
        else if (cell_en) cell_q <= wr_data[c*DW +: DW];
      end

      assign store_flat[(c*NUM_REG + r)*DW +: DW] = cell_q;
    end
  end

endmodule

// File: rtl/nvreg_req.sv
module nvreg_req
  import nvreg_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_REG = 4,
  parameter int unsigned DW      = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [$clog2(NUM_REG)-1:0]  req_reg,
  input  logic [$clog2(NUM_CH)-1:0]   req_ch,
  input  logic [DW-1:0]               req_wdata,
  input  logic [NUM_CH*DW-1:0]        wip_cur,
  input  logic                        wp_n,
  input  logic                        busy,
  input  logic                        cmd_stop,
  output logic                        reject,
  output logic                        commit,
  output logic [NUM_CH-1:0]           commit_mask,
  output logic [$clog2(NUM_REG)-1:0]  commit_sel,
  output logic [NUM_CH*DW-1:0]        commit_data
);

  localparam int unsigned RW = $clog2(NUM_REG);

  logic                pend_q, pend_d, pend_en;
  logic [NUM_CH-1:0]   mask_q, mask_d;
  logic [RW-1:0]       sel_q, sel_d;
  logic [NUM_CH*DW-1:0] data_q, data_d;
  logic                capt_en;
  logic                rej_q, rej_d;
  logic                mod_req, free;

  assign mod_req = req_valid && op_modifies(req_op);
  assign free    = !busy && !pend_q;
  assign capt_en = mod_req && free && wp_n;
  assign rej_d   = mod_req && free && !wp_n;

  always_comb begin
    mask_d = '0;
    sel_d  = req_reg;
    data_d = wip_cur;
    case (req_op)
      OP_WR_REG: begin
        mask_d = NUM_CH'(1) << req_ch;
        data_d = {NUM_CH{req_wdata}};
      end
      OP_WIP2REG:  mask_d = NUM_CH'(1) << req_ch;
      OP_GLB_SAVE: mask_d = '1;
      default:     mask_d = '0;
    endcase
  end

  always_comb begin
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (capt_en) begin
      pend_en = 1'b1;
      pend_d  = 1'b1;
    end else if (commit) begin
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= '0;
      data_q <= '0;
    end else if (capt_en) begin
      mask_q <= mask_d;
      sel_q  <= sel_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej_d;
  end

  assign commit      = cmd_stop && pend_q;
  assign commit_mask = commit ? mask_q : '0;
  assign commit_sel  = sel_q;
  assign commit_data = data_q;
  assign reject      = rej_q;

endmodule

// File: rtl/nvreg_bank_ctrl.sv
module nvreg_bank_ctrl
  import nvreg_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned NUM_REG     = 4,
  parameter int unsigned DW          = 6,
  parameter int unsigned BUSY_CYCLES = 500000,
  parameter int unsigned RST_VAL     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [$clog2(NUM_REG)-1:0]  req_reg,
  input  logic [$clog2(NUM_CH)-1:0]   req_ch,
  input  logic [DW-1:0]               req_wdata,
  input  logic                        wp_n,
  input  logic                        cmd_stop,
  input  logic [NUM_CH*DW-1:0]        wip_cur,
  output logic                        busy,
  output logic                        reject,
  output logic                        rd_valid,
  output logic [DW-1:0]               rd_data,
  output logic [NUM_CH-1:0]           wip_ld,
  output logic [NUM_CH*DW-1:0]        wip_ld_data
);

  localparam int unsigned RW = $clog2(NUM_REG);
  localparam int unsigned SW = NUM_CH*NUM_REG*DW;

  logic                rst_sn;
  logic [SW-1:0]       store_flat;
  logic                commit;
  logic [NUM_CH-1:0]   commit_mask;
  logic [RW-1:0]       commit_sel;
  logic [NUM_CH*DW-1:0] commit_data;

  nvreg_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  nvreg_req #(.NUM_CH(NUM_CH), .NUM_REG(NUM_REG), .DW(DW)) u_req (
    .clk         (clk),
    .rst_n       (rst_sn),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_reg     (req_reg),
    .req_ch      (req_ch),
    .req_wdata   (req_wdata),
    .wip_cur     (wip_cur),
    .wp_n        (wp_n),
    .busy        (busy),
    .cmd_stop    (cmd_stop),
    .reject      (reject),
    .commit      (commit),
    .commit_mask (commit_mask),
    .commit_sel  (commit_sel),
    .commit_data (commit_data)
  );

  nvreg_store #(.NUM_CH(NUM_CH), .NUM_REG(NUM_REG), .DW(DW), .RST_VAL(RST_VAL)) u_store (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_en      (commit_mask),
    .wr_sel     (commit_sel),
    .wr_data    (commit_data),
    .store_flat (store_flat)
  );

  nvreg_wcycle #(.BUSY_CYCLES(BUSY_CYCLES)) u_wcyc (
    .clk   (clk),
    .rst_n (rst_sn),
    .start (commit),
    .busy  (busy)
  );

  // read path
  logic          rd_req;
  logic [DW-1:0] rd_sel_val;
  logic          rdv_q;
  logic [DW-1:0] rdd_q;

  assign rd_req     = req_valid && (req_op == OP_RD_REG);
  assign rd_sel_val = store_flat[(int'(req_ch)*NUM_REG + int'(req_reg))*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdd_q <= '0;
    else if (rd_req) rdd_q <= rd_sel_val;
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  // wiper recall path
  logic                 boot_q;
  logic [RW-1:0]        rcl_sel;
  logic [NUM_CH*DW-1:0] rcl_lanes;
  logic [NUM_CH-1:0]    ld_d, ld_q;
  logic [NUM_CH*DW-1:0] ldd_q;
  logic                 ld_en;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     boot_q <= 1'b1;
    else if (boot_q) boot_q <= 1'b0;
  end

  assign rcl_sel = boot_q ? '0 : req_reg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rcl
    assign rcl_lanes[c*DW +: DW] = store_flat[(c*NUM_REG + int'(rcl_sel))*DW +: DW];
  end

  always_comb begin
    ld_d = '0;
    if (boot_q)
      ld_d = '1;
    else if (req_valid && req_op == OP_REG2WIP)
      ld_d = NUM_CH'(1) << req_ch;
    else if (req_valid && req_op == OP_GLB_RECALL)
      ld_d = '1;
  end

  assign ld_en = (ld_d != '0);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ld_q <= '0;
    else         ld_q <= ld_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ldd_q <= '0;
    else if (ld_en)  ldd_q <= rcl_lanes;
  end

  assign wip_ld      = ld_q;
  assign wip_ld_data = ldd_q;

endmodule

// File: rtl/nvreg_bank_ctrl_chk.sv
module nvreg_bank_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SW     = 96
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              wp_n,
  input logic              cmd_stop,
  input logic              busy,
  input logic              reject,
  input logic              rd_valid,
  input logic [NUM_CH-1:0] wip_ld,
  input logic [SW-1:0]     store_flat
);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> $past(cmd_stop));

  // R9
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    reject |-> $past(req_valid && !wp_n));

  // R2
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid |-> $past(req_valid && req_op == 3'd1));

  // R11
  wip_ld_shape_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wip_ld != '0) |-> ($onehot(wip_ld) || (&wip_ld)));

  // R10
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy)) |-> $stable(store_flat));

  // R5
  recall_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ($onehot(wip_ld) && !$past(busy) && !$past(cmd_stop)) |-> !busy);

endmodule

bind nvreg_bank_ctrl nvreg_bank_ctrl_chk #(.NUM_CH(NUM_CH), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .wp_n       (wp_n),
  .cmd_stop   (cmd_stop),
  .busy       (busy),
  .reject     (reject),
  .rd_valid   (rd_valid),
  .wip_ld     (wip_ld),
  .store_flat (store_flat)
);

// File: tb/nvreg_bank_ctrl_tb.sv
module nvreg_bank_ctrl_tb;

  localparam int BUSY = 6;
  localparam int RV   = 33;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [1:0]  req_reg;
  logic [1:0]  req_ch;
  logic [5:0]  req_wdata;
  logic        wp_n;
  logic        cmd_stop;
  logic [23:0] wip_cur;
  logic        busy;
  logic        reject;
  logic        rd_valid;
  logic [5:0]  rd_data;
  logic [3:0]  wip_ld;
  logic [23:0] wip_ld_data;

  int total = 0;
  int bad   = 0;

  nvreg_bank_ctrl #(.BUSY_CYCLES(BUSY), .RST_VAL(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_ch(req_ch), .req_wdata(req_wdata), .wp_n(wp_n),
    .cmd_stop(cmd_stop), .wip_cur(wip_cur), .busy(busy), .reject(reject),
    .rd_valid(rd_valid), .rd_data(rd_data), .wip_ld(wip_ld),
    .wip_ld_data(wip_ld_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] r, input logic [1:0] c,
                       input logic [5:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_reg = r; req_ch = c; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [1:0] r, input logic [1:0] c,
                          input logic [5:0] exp);
    issue(3'd1, r, c, 6'd0);
    chk({req, " rd_valid"}, rd_valid, 1);
    chk({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic busy_len(input string req, output int n);
    n = 0;
    for (int i = 0; i < 60 && busy; i++) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int seen;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 reject in reset", reject, 0);
    chk("R1 rd_valid in reset", rd_valid, 0);
    chk("R1 wip_ld in reset", wip_ld, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 8 && seen == 0; i++) begin
      @(negedge clk);
      if (wip_ld != 0) seen = 1;
    end
    chk("R1 boot recall strobe", wip_ld, 4'hF);
    for (int c = 0; c < 4; c++) chk("R1 boot recall data", wip_ld_data[c*6 +: 6], RV);
    @(negedge clk);
    chk("R1 boot recall once", wip_ld, 0);
  endtask

  task automatic t_write_commit();
    int n;
    issue(3'd0, 2'd1, 2'd2, 6'h15);
    chk("R3 no busy before stop", busy, 0);
    read_chk("R3 old value before stop", 2'd1, 2'd2, RV);
    stop_pulse();
    busy_len("R4", n);
    chk("R4 busy length", n, BUSY);
    read_chk("R2 R3 value after stop", 2'd1, 2'd2, 6'h15);
    stop_pulse();
    chk("R4 idle stop keeps busy low", busy, 0);
  endtask

  task automatic t_reg2wip();
    issue(3'd2, 2'd1, 2'd2, 6'd0);
    chk("R5 one-hot strobe", wip_ld, 4'b0100);
    chk("R5 lane data", wip_ld_data[12 +: 6], 6'h15);
    chk("R5 no busy", busy, 0);
    @(negedge clk);
    chk("R11 strobe clears", wip_ld, 0);
  endtask

  task automatic t_wip2reg();
    int n;
    wip_cur = {6'h07, 6'h2A, 6'h11, 6'h3E};
    issue(3'd3, 2'd3, 2'd1, 6'd0);
    wip_cur = '0;
    stop_pulse();
    busy_len("R7", n);
    read_chk("R7 wiper saved at request", 2'd3, 2'd1, 6'h11);
    read_chk("R7 other channel untouched", 2'd3, 2'd0, RV);
  endtask

  task automatic t_glb_save();
    int n;
    wip_cur = {6'h01, 6'h02, 6'h03, 6'h04};
    issue(3'd5, 2'd2, 2'd0, 6'd0);
    wip_cur = {4{6'h3F}};
    stop_pulse();
    busy_len("R8", n);
    chk("R8 busy length", n, BUSY);
    for (int c = 0; c < 4; c++)
      read_chk("R8 global save", 2'd2, 2'(c), 6'(4 - c));
  endtask

  task automatic t_glb_recall();
    issue(3'd4, 2'd2, 2'd0, 6'd0);
    chk("R6 all strobes", wip_ld, 4'hF);
    for (int c = 0; c < 4; c++)
      chk("R6 recall lane", wip_ld_data[c*6 +: 6], 6'(4 - c));
    chk("R6 no busy", busy, 0);
  endtask

  task automatic t_wp_reject();
    wp_n = 1'b0;
    issue(3'd0, 2'd0, 2'd0, 6'h0A);
    chk("R9 reject pulse", reject, 1);
    @(negedge clk);
    chk("R9 reject one cycle", reject, 0);
    issue(3'd5, 2'd0, 2'd0, 6'd0);
    chk("R9 reject global save", reject, 1);
    stop_pulse();
    chk("R9 no busy after stop", busy, 0);
    wp_n = 1'b1;
    read_chk("R9 register unchanged", 2'd0, 2'd0, RV);
    read_chk("R9 save did not land", 2'd0, 2'd3, RV);
  endtask

  task automatic t_busy_ignore();
    int n;
    issue(3'd0, 2'd0, 2'd3, 6'h2C);
    stop_pulse();
    chk("R10 busy started", busy, 1);
    wp_n = 1'b0;
    issue(3'd0, 2'd0, 2'd3, 6'h05);
    chk("R10 no reject while busy", reject, 0);
    wp_n = 1'b1;
    issue(3'd0, 2'd0, 2'd3, 6'h06);
    read_chk("R2 read served while busy", 2'd0, 2'd3, 6'h2C);
    busy_len("R10", n);
    stop_pulse();
    chk("R10 ignored write left nothing pending", busy, 0);
    read_chk("R10 busy write dropped", 2'd0, 2'd3, 6'h2C);
    issue(3'd0, 2'd1, 2'd3, 6'h12);
    issue(3'd0, 2'd1, 2'd3, 6'h13);
    stop_pulse();
    busy_len("R10", n);
    read_chk("R10 first pending wins", 2'd1, 2'd3, 6'h12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_op = 3'd0; req_reg = 2'd0; req_ch = 2'd0;
    req_wdata = 6'd0; wp_n = 1'b1; cmd_stop = 1'b0; wip_cur = '0;
    rst_n = 1'b0;
    t_reset();
    t_write_commit();
    t_reg2wip();
    t_wip2reg();
    t_glb_save();
    t_glb_recall();
    t_wp_reject();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule